// File: doc/BRIEF.md
# Configurable CRC and Checksum Engine

This block computes cyclic redundancy checks and a 16-bit ones'-complement checksum over data that software pushes into it word by word. It holds four registers on one 32-bit port: a control register, a running-value (seed) register, a data-feed register and a result register. Every write to the feed register folds a whole 32-bit word, or one byte, into the running value in a single clock cycle.

The control register picks the algorithm, the input width, how the input word is shuffled and bit-reversed before use, and how the result is reversed and inverted before it lands in the result register. A start-value field tells the next feed write where to begin: from the running value, from all zeros or from all ones. The field returns to zero by itself once a feed write has used it, so the writes that follow continue the same computation.

Register addresses: 0 is control, 1 is the running value, 2 is the data feed and 3 is the result. Writes use `wr_en`, `wr_addr` and `wr_data`. Reads are combinational from `rd_addr` to `rd_data`.

Top module: `crce_top`

## Requirements
- R1: After reset all four registers read zero. The control register reads back the written value masked to its defined bits (mask 0x000073BF), and unused bits read as zero.
- R2: The control field kind in bits [3:0] selects the algorithm: 0000 is a 16-bit CRC with polynomial 0x8005, 0001 is a 16-bit CRC with 0x1021, 0010 is a 32-bit CRC with 0x04C11DB7, 0011 is a 32-bit CRC with 0x1EDC6F41, and 1000 is the checksum. A feed write under any other kind changes no register.
- R3: The control field start in bits [14:13] sets where an accepted feed write begins: 10 begins from zero, 11 from all ones, and 00 or 01 from the running value. The start value is cut to 16 bits for 16-bit kinds.
- R4: An accepted feed write sets the start field to 00 in the same cycle that it updates the running value. The field stays 00 until control is written again.
- R5: When control bit 12 is 1, only bits [7:0] of the shaped input word are processed. When it is 0, all 32 bits are processed.
- R6: Input shaping swaps the bytes within each half-word when control bit 4 is set, and swaps the two half-words when bit 5 is set. After that, bit 7 reverses the bit order within every byte.
- R7: A CRC shifts the shaped input in most-significant bit first, one feed word per cycle. For the 16-bit kinds the running value sits in bits [15:0] and bits [31:16] read zero.
- R8: The checksum adds 16-bit values into a 16-bit accumulator with end-around carry. A 32-bit feed adds bits [31:16] first and then bits [15:0]. An 8-bit feed adds the byte with its upper byte zero.
- R9: On each accepted feed write the result register loads the new running value after two steps: bit 8 reverses the bits within each byte, and then bit 9 inverts all 32 bits. The running-value register keeps the raw value.
- R10: A write to address 1 replaces the running value. A write to address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Combinational read data |

## Verification
On a single feed write, two things happen in one cycle: the pending start value is consumed and the start field clears itself. The bench sets the start field to 10 or 11 on a running value that is not zero. It then issues back-to-back feed writes and judges two things: the first write must begin from the selected constant, and the second must continue from the first write's result. The bench also reads control back to check that its start field reads 00 right after the first write. A reserved kind with a pending start value is also fed, to show that a write that is not accepted neither consumes nor clears that value.

// File: rtl/crce_pkg.sv
package crce_pkg;

   typedef enum logic [1:0] {
      A_CFG  = 2'd0,
      A_SEED = 2'd1,
      A_FEED = 2'd2,
      A_RES  = 2'd3
   } addr_e;

   localparam logic [3:0] K_CRC16A = 4'b0000;
   localparam logic [3:0] K_CRC16B = 4'b0001;
   localparam logic [3:0] K_CRC32A = 4'b0010;
   localparam logic [3:0] K_CRC32B = 4'b0011;
   localparam logic [3:0] K_SUM16  = 4'b1000;

   localparam logic [1:0] ST_ZERO = 2'b10;
   localparam logic [1:0] ST_ONES = 2'b11;

   // field layout follows the control word bit positions
   typedef struct packed {
      logic [1:0] start;    // 14:13
      logic       narrow;   // 12
      logic [1:0] pad_hi;   // 11:10
      logic       out_inv;  // 9
      logic       out_rev;  // 8
      logic       in_rev;   // 7
      logic       pad_lo;   // 6
      logic [1:0] order;    // 5:4
      logic [3:0] kind;     // 3:0
   } cfg_t;

   function automatic logic [15:0] add1c(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'b0, s[16]};
   endfunction

endpackage

// File: rtl/crce_in_shaper.sv
module crce_in_shaper #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic [1:0]        order,
   input  logic              in_rev,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int NBYTES = WORD_W / BYTE_W;

   if (WORD_W != 32 || BYTE_W != 8) begin : g_bad_w
      $error("crce_in_shaper: only a 32-bit word of 8-bit bytes is supported");
   end

   logic [WORD_W-1:0] sw_b, sw_h, rev_w;

   assign sw_b = order[0] ? {word_i[23:16], word_i[31:24], word_i[7:0], word_i[15:8]} : word_i;
   assign sw_h = order[1] ? {sw_b[15:0], sw_b[31:16]} : sw_b;

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
         assign rev_w[g*BYTE_W + k] = sw_h[g*BYTE_W + BYTE_W-1-k];
      end
   end

   assign word_o = in_rev ? rev_w : sw_h;
endmodule

// File: rtl/crce_crc_fold.sv
module crce_crc_fold #(
   parameter int CRC_W  = 16,
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic [CRC_W-1:0]  crc_i,
   input  logic [CRC_W-1:0]  poly,
   input  logic [WORD_W-1:0] data,
   input  logic              narrow,
   output logic [CRC_W-1:0]  crc_o
);
   if (CRC_W < 2 || CRC_W > WORD_W) begin : g_bad_w
      $error("crce_crc_fold: CRC_W out of range");
   end

   logic [WORD_W-1:0] d;
   logic [CRC_W-1:0]  c;
   logic              fb;

   always_comb begin
      d  = narrow ? {data[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}} : data;
      c  = crc_i;
      fb = 1'b0;
      for (int i = 0; i < WORD_W; i++) begin
         if (!narrow || i < BYTE_W) begin
            fb = c[CRC_W-1] ^ d[WORD_W-1-i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : {CRC_W{1'b0}});
         end
      end
      crc_o = c;
   end
endmodule

// File: rtl/crce_out_shaper.sv
module crce_out_shaper #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              out_rev,
   input  logic              out_inv,
   input  logic [WORD_W-1:0] val_i,
   output logic [WORD_W-1:0] val_o
);
   localparam int NBYTES = WORD_W / BYTE_W;

   if (WORD_W % BYTE_W != 0) begin : g_bad_w
      $error("crce_out_shaper: WORD_W must be whole bytes");
   end

   logic [WORD_W-1:0] rev_w, pick;

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
         assign rev_w[g*BYTE_W + k] = val_i[g*BYTE_W + BYTE_W-1-k];
      end
   end

   assign pick  = out_rev ? rev_w : val_i;
   assign val_o = out_inv ? ~pick : pick;
endmodule

// File: rtl/crce_top.sv
module crce_top
   import crce_pkg::*;
#(
   parameter int          WORD_W  = 32,
   parameter int          SHORT_W = 16,
   parameter logic [15:0] POLY_A  = 16'h8005,
   parameter logic [15:0] POLY_B  = 16'h1021,
   parameter logic [31:0] POLY_C  = 32'h04C11DB7,
   parameter logic [31:0] POLY_D  = 32'h1EDC6F41
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic [1:0]  rd_addr,
   output logic [31:0] rd_data
);
   localparam int CFG_W = $bits(cfg_t);

   if (WORD_W != 32 || SHORT_W != 16) begin : g_bad_w
      $error("crce_top: word must be 32 bits and short value 16 bits");
   end

   cfg_t              cfg_q, cfg_d;
   logic [WORD_W-1:0] run_q, res_q;
   logic [WORD_W-1:0] start_raw, start_v, shaped, next_run, next_res;
   logic [SHORT_W-1:0] crc16_o, sum_o;
   logic [WORD_W-1:0]  crc32_o;
   logic              is_short, kind_ok, feed_we;

   always_comb begin
      unique case (cfg_q.kind)
         K_CRC16A, K_CRC16B, K_SUM16: begin kind_ok = 1'b1; is_short = 1'b1; end
         K_CRC32A, K_CRC32B:          begin kind_ok = 1'b1; is_short = 1'b0; end
         default:                     begin kind_ok = 1'b0; is_short = 1'b0; end
      endcase
   end

   assign feed_we = wr_en && (wr_addr == A_FEED) && kind_ok;

   always_comb begin
      case (cfg_q.start)
         ST_ZERO: start_raw = '0;
         ST_ONES: start_raw = '1;
         default: start_raw = run_q;
      endcase
      start_v = is_short ? {{(WORD_W-SHORT_W){1'b0}}, start_raw[SHORT_W-1:0]} : start_raw;
   end

   crce_in_shaper #(.WORD_W(WORD_W), .BYTE_W(8)) u_in (
      .order (cfg_q.order),
      .in_rev(cfg_q.in_rev),
      .word_i(wr_data),
      .word_o(shaped)
   );

   crce_crc_fold #(.CRC_W(SHORT_W), .WORD_W(WORD_W), .BYTE_W(8)) u_crc16 (
      .crc_i (start_v[SHORT_W-1:0]),
      .poly  (cfg_q.kind[0] ? POLY_B : POLY_A),
      .data  (shaped),
      .narrow(cfg_q.narrow),
      .crc_o (crc16_o)
   );

   crce_crc_fold #(.CRC_W(WORD_W), .WORD_W(WORD_W), .BYTE_W(8)) u_crc32 (
      .crc_i (start_v),
      .poly  (cfg_q.kind[0] ? POLY_D : POLY_C),
      .data  (shaped),
      .narrow(cfg_q.narrow),
      .crc_o (crc32_o)
   );

   // checksum: one or two end-around additions
   assign sum_o = cfg_q.narrow
                ? add1c(start_v[15:0], {8'h00, shaped[7:0]})
                : add1c(add1c(start_v[15:0], shaped[31:16]), shaped[15:0]);

   always_comb begin
      if (cfg_q.kind == K_SUM16)
         next_run = {{(WORD_W-SHORT_W){1'b0}}, sum_o};
      else if (is_short)
         next_run = {{(WORD_W-SHORT_W){1'b0}}, crc16_o};
      else
         next_run = crc32_o;
   end

   crce_out_shaper #(.WORD_W(WORD_W), .BYTE_W(8)) u_out (
      .out_rev(cfg_q.out_rev),
      .out_inv(cfg_q.out_inv),
      .val_i  (next_run),
      .val_o  (next_res)
   );

   always_comb begin
      cfg_d        = cfg_t'(wr_data[CFG_W-1:0]);
      cfg_d.pad_hi = '0;
      cfg_d.pad_lo = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         run_q <= '0;
         res_q <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CFG:  cfg_q <= cfg_d;
            A_SEED: run_q <= wr_data;
            A_FEED: if (kind_ok) begin
                       run_q       <= next_run;
                       res_q       <= next_res;
                       cfg_q.start <= 2'b00;
                    end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         A_CFG:   rd_data = {{(32-CFG_W){1'b0}}, cfg_q};
         A_SEED:  rd_data = run_q;
         A_FEED:  rd_data = '0;
         default: rd_data = res_q;
      endcase
   end

   // R4
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      feed_we |=> (cfg_q.start == 2'b00));

   // R7
   short_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (feed_we && is_short) |=> (run_q[WORD_W-1:SHORT_W] == '0));

   // R2
   reserved_kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_FEED && !kind_ok) |=> ($stable(run_q) && $stable(res_q)));

   // R10
   result_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_RES) |=> $stable(res_q));

   // R1
   cfg_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.pad_hi == 2'b00) && !cfg_q.pad_lo);
endmodule

// File: tb/crce_top_tb_top.sv
`timescale 1ns/1ps
module crce_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic [1:0]  rd_addr = 2'd0;
   logic [31:0] rd_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   string cur_req = "R1";

   logic [31:0] m_cfg = 0, m_run = 0, m_res = 0;

   always #4 clk = ~clk;

   crce_top dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [7:0] rbyte(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
      int unsigned s;
      s = a + b;
      if (s > 32'hFFFF) s = s - 32'hFFFF;
      return s[15:0];
   endfunction

   function automatic logic [31:0] ref_feed(input logic [31:0] cfg, input logic [31:0] run, input logic [31:0] din);
      logic [7:0] b [4];
      logic [7:0] t;
      logic [3:0] kind;
      int w;
      longint unsigned v, poly, msk;
      logic [7:0] seq [$];
      kind = cfg[3:0];
      w = (kind == 4'd2 || kind == 4'd3) ? 32 : 16;
      msk = (w == 32) ? 64'hFFFF_FFFF : 64'hFFFF;
      case (cfg[14:13])
         2'b10: v = 0;
         2'b11: v = msk;
         default: v = run & msk;
      endcase
      for (int i = 0; i < 4; i++) b[i] = din[8*i +: 8];
      if (cfg[4]) begin t = b[0]; b[0] = b[1]; b[1] = t; t = b[2]; b[2] = b[3]; b[3] = t; end
      if (cfg[5]) begin t = b[0]; b[0] = b[2]; b[2] = t; t = b[1]; b[1] = b[3]; b[3] = t; end
      if (cfg[7]) for (int i = 0; i < 4; i++) b[i] = rbyte(b[i]);
      if (cfg[12]) seq.push_back(b[0]);
      else begin seq.push_back(b[3]); seq.push_back(b[2]); seq.push_back(b[1]); seq.push_back(b[0]); end
      if (kind == 4'd8) begin
         if (cfg[12]) v = oc_add(v[15:0], {8'h00, b[0]});
         else v = oc_add(oc_add(v[15:0], {b[3], b[2]}), {b[1], b[0]});
      end else begin
         case (kind)
            4'd0: poly = 64'h8005;
            4'd1: poly = 64'h1021;
            4'd2: poly = 64'h04C11DB7;
            default: poly = 64'h1EDC6F41;
         endcase
         foreach (seq[k]) begin
            for (int j = 7; j >= 0; j--) begin
               bit top;
               top = v[w-1] ^ seq[k][j];
               v = (v << 1) & msk;
               if (top) v = v ^ poly;
            end
         end
      end
      return v[31:0];
   endfunction

   function automatic logic [31:0] ref_out(input logic [31:0] cfg, input logic [31:0] v);
      logic [31:0] r;
      r = v;
      if (cfg[8]) for (int i = 0; i < 4; i++) r[8*i +: 8] = rbyte(v[8*i +: 8]);
      if (cfg[9]) r = ~r;
      return r;
   endfunction

   function automatic bit kind_valid(input logic [3:0] k);
      return (k <= 4'd3) || (k == 4'd8);
   endfunction

   task automatic model_apply(input bit en, input logic [1:0] a, input logic [31:0] d);
      logic [31:0] nv;
      if (!en) return;
      case (a)
         2'd0: m_cfg = d & 32'h0000_73BF;
         2'd1: m_run = d;
         2'd2: if (kind_valid(m_cfg[3:0])) begin
                  nv = ref_feed(m_cfg, m_run, d);
                  m_run = nv;
                  m_res = ref_out(m_cfg, nv);
                  m_cfg[14:13] = 2'b00;
               end
         default: ;
      endcase
   endtask

   task automatic compare_all();
      for (int a = 0; a < 4; a++) begin
         rd_addr = a[1:0];
         #0.5;
         case (a)
            0: check({cur_req, " cfg"}, rd_data, m_cfg);
            1: check({cur_req, " run"}, rd_data, m_run);
            2: check({cur_req, " feed"}, rd_data, 32'h0);
            default: check({cur_req, " res"}, rd_data, m_res);
         endcase
      end
   endtask

   // drive one cycle, update model after the edge, compare mid low phase
   task automatic step(input bit en, input logic [1:0] a, input logic [31:0] d);
      wr_en = en; wr_addr = a; wr_data = d;
      @(posedge clk);
      model_apply(en, a, d);
      @(negedge clk);
      wr_en = 1'b0;
      compare_all();
   endtask

   task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
      rd_addr = a; #0.5;
      check(req, rd_data, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8.0 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   initial begin
      string digits = "123456789";
      @(negedge clk);
      cur_req = "R1";
      compare_all();
      rst_n = 1'b1;
      step(0, 0, 0);
      step(1, 0, 32'hFFFF_FFFF);             // R1 mask check
      rd_check("R1", 2'd0, 32'h0000_73BF);

      // R7: 16-bit 0x1021 from all ones over nine bytes
      cur_req = "R7";
      step(1, 0, 32'h0000_7001);
      for (int i = 0; i < 9; i++) begin
         step(1, 2, {24'h0, digits[i]});
         if (i == 0) rd_check("R4", 2'd0, 32'h0000_1001);
      end
      rd_check("R7", 2'd3, 32'h0000_29B1);

      // R9 with R6 in_rev: reflected 32-bit CRC, per-byte reversed output, inverted
      cur_req = "R9";
      step(1, 0, 32'h0000_7382);
      for (int i = 0; i < 9; i++) step(1, 2, {24'h0, digits[i]});
      rd_check("R9", 2'd3, 32'h2639_F4CB);

      // R8 checksum, 32-bit feeds from zero
      cur_req = "R8";
      step(1, 0, 32'h0000_4008);
      step(1, 2, 32'h0001_F203);
      step(1, 2, 32'hF4F5_F6F7);
      rd_check("R8", 2'd3, 32'h0000_DDF2);
      step(1, 0, 32'h0000_1008);             // narrow checksum
      step(1, 2, 32'h1234_56FF);

      // R10: seed write and result write ignored
      cur_req = "R10";
      step(1, 3, 32'h1234_5678);
      rd_check("R10", 2'd3, m_res);
      step(1, 1, 32'hA5A5_0F0F);
      rd_check("R10", 2'd1, 32'hA5A5_0F0F);
      step(1, 0, 32'h0000_2003);             // start 01 uses running value
      cur_req = "R3";
      step(1, 2, 32'hDEAD_BEEF);
      step(1, 0, 32'h0000_4002);             // start zeros on nonzero running value
      step(1, 2, 32'h0102_0304);
      step(1, 2, 32'h0506_0708);             // back to back: continues
      step(1, 0, 32'h0000_6000);
      step(1, 2, 32'hCAFE_F00D);
      rd_check("R4", 2'd0, 32'h0000_0000);

      // R2: reserved kind with a pending start value
      cur_req = "R2";
      step(1, 0, 32'h0000_6005);
      step(1, 2, 32'h1111_2222);
      rd_check("R2", 2'd0, 32'h0000_6005);
      rd_check("R2", 2'd1, m_run);
      for (int k = 0; k < 5; k++) begin
         step(1, 0, 32'h0000_6000 | k);
         step(1, 2, 32'h89AB_CDEF);
      end

      // R6 and R5: all shaping orders, both widths
      cur_req = "R6";
      for (int o = 0; o < 8; o++) begin
         step(1, 0, 32'h0000_6002 | ((o & 3) << 4) | ((o >> 2) << 7) | 32'h1000);
         step(1, 2, 32'h1234_5678);
         step(1, 0, 32'h0000_6000 | ((o & 3) << 4) | ((o >> 2) << 7));
         step(1, 2, 32'h1234_5678);
      end
      cur_req = "R5";
      step(1, 0, 32'h0000_7003);
      step(1, 2, 32'hFFFF_FF5A);
      step(1, 0, 32'h0000_6003);
      step(1, 2, 32'h0000_005A);

      // mixed traffic
      cur_req = "R9";
      for (int n = 0; n < 400; n++) begin
         logic [31:0] r;
         r = $urandom();
         if (r[2:0] == 3'd0) step(1, 0, $urandom());
         else if (r[2:0] == 3'd1) step(1, 1, $urandom());
         else if (r[2:0] == 3'd2) step(1, 3, $urandom());
         else if (r[2:0] == 3'd3) step(0, 2, $urandom());
         else step(1, 2, $urandom());
      end
      finish_run();
   end
endmodule